// File: doc/BRIEF.md
# Event Interrupt Register Bank

This block gathers three single-cycle hardware event pulses (channel 0, channel 1 and counter overflow) into sticky raw status flags. Each flag has an enable bit in a mask register. The masked status is the AND of the two vectors, and a single level interrupt line is raised while any masked flag is set. Software polls the raw view and acknowledges events through a write-one-to-clear port. That port works whether or not the event is enabled. Software can also inject events through a write-one-to-set port for diagnostics.

The mask can be written whole, or changed bit by bit through its own set-only and clear-only ports, so no read-modify-write sequence is needed. Access is through a plain synchronous register port. A write is taken on any clock edge where the write enable is high. Read data is a combinational view of the register selected by the same address. There is no handshake and no back-pressure: every write is accepted in the cycle it is presented.

The event bit positions are fixed. Channel 0 is bit 0, channel 1 is bit 1 and overflow is bit 6. The word addresses are:

| Address | Register | Access |
|---|---|---|
| 0 | raw status | read-only |
| 1 | mask | read/write |
| 2 | masked status | read-only |
| 3 | status set | write-one-to-set |
| 4 | status clear | write-one-to-clear |
| 5 | mask set | write-one-to-set |
| 6 | mask clear | write-one-to-clear |
| 7 | unused | reads as zero |

Top module: `evt_irq_bank`

## Requirements
- R1: After reset, every address reads 0 and `irq` is low.
- R2: A one-cycle pulse on `evt_ch0`, `evt_ch1` or `evt_ovf` sets raw status bit 0, 1 or 6 respectively at the next clock edge. The flag stays set until software clears it.
- R3: Address 2 reads the bitwise AND of raw status (address 0) and mask (address 1).
- R4: A write to address 3 sets every raw flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. Address 3 reads as 0.
- R5: A write to address 4 clears every raw flag whose data bit is 1, whether that event is masked or enabled. Data bits that are 0 have no effect, and address 4 reads as 0.
- R6: Address 1 holds the mask and can be written directly and read back.
- R7: A write to address 5 sets the mask bits whose data bit is 1, and a write to address 6 clears them. Data bits that are 0 have no effect, and both addresses read as 0.
- R8: Bits other than 0, 1 and 6 always read as 0 and ignore writes. Writes to addresses 0, 2 and 7 change nothing, and address 7 reads as 0.
- R9: When a hardware event pulse and a software clear of the same flag land on the same clock edge, the flag ends up set.
- R10: `irq` is high exactly when at least one masked status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Write enable, taken on the rising clock edge |
| reg_addr | input | ADDR_W | Word address for both write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| evt_ch0 | input | 1 | Channel 0 event pulse |
| evt_ch1 | input | 1 | Channel 1 event pulse |
| evt_ovf | input | 1 | Counter overflow event pulse |
| irq | output | 1 | Level interrupt: OR of the masked status bits |

## Verification
The bench builds the block with its default parameters: a 32-bit data path and a 3-bit address. The wide data path lets writes of all ones reach the 29 unused bit positions, so the bench can confirm that they stay zero. The 3-bit address covers every register and also the spare address 7. At these settings the bench can drive an event pulse and a clear of the same flag on one edge, and it can exercise masked against unmasked clears on each of the three bit positions.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int NUM_EVT = 3;
  // Bit position of each event in the status and mask words, in event order.
  localparam int EVT_POS [NUM_EVT] = '{0, 1, 6};

  localparam int A_RAW    = 0;
  localparam int A_MASK   = 1;
  localparam int A_MASKED = 2;
  localparam int A_ST_SET = 3;
  localparam int A_ST_CLR = 4;
  localparam int A_MK_SET = 5;
  localparam int A_MK_CLR = 6;

  typedef struct packed {
    logic mask_wr;
    logic st_set;
    logic st_clr;
    logic mk_set;
    logic mk_clr;
  } wr_strb_t;
endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  output wr_strb_t          strb
);
  always_comb begin
    strb         = '0;
    strb.mask_wr = wen && (addr == ADDR_W'(A_MASK));
    strb.st_set  = wen && (addr == ADDR_W'(A_ST_SET));
    strb.st_clr  = wen && (addr == ADDR_W'(A_ST_CLR));
    strb.mk_set  = wen && (addr == ADDR_W'(A_MK_SET));
    strb.mk_clr  = wen && (addr == ADDR_W'(A_MK_CLR));
  end
endmodule

// File: rtl/evt_irq_slice.sv
module evt_irq_slice
  import evt_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hw_evt,
  input  wr_strb_t strb,
  input  logic     wbit,
  output logic     raw_q,
  output logic     mask_q
);
  // The hardware pulse and a software set take priority over a software clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
    end else if (hw_evt || (strb.st_set && wbit)) begin
      raw_q <= 1'b1;
    end else if (strb.st_clr && wbit) begin
      raw_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
    end else if (strb.mask_wr) begin
      mask_q <= wbit;
    end else if (strb.mk_set && wbit) begin
      mask_q <= 1'b1;
    end else if (strb.mk_clr && wbit) begin
      mask_q <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_irq_rdmux.sv
module evt_irq_rdmux
  import evt_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] raw_vec,
  input  logic [DATA_W-1:0] mask_vec,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [DATA_W-1:0] masked_vec;

  assign masked_vec = raw_vec & mask_vec;
  assign irq        = |masked_vec;

  // Set-only and clear-only ports fall through to the default and read as zero.
  always_comb begin
    case (addr)
      ADDR_W'(A_RAW):    rdata = raw_vec;
      ADDR_W'(A_MASK):   rdata = mask_vec;
      ADDR_W'(A_MASKED): rdata = masked_vec;
      default:           rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_bank.sv
module evt_irq_bank
  import evt_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evt_ch0,
  input  logic              evt_ch1,
  input  logic              evt_ovf,
  output logic              irq
);
  wr_strb_t            strb;
  logic [NUM_EVT-1:0]  evt_vec;
  logic [NUM_EVT-1:0]  raw_bits;
  logic [NUM_EVT-1:0]  mask_bits;
  logic [NUM_EVT-1:0]  wbits;
  logic [DATA_W-1:0]   raw_vec;
  logic [DATA_W-1:0]   mask_vec;
  logic                unused_wdata;

  assign evt_vec = {evt_ovf, evt_ch1, evt_ch0};

  evt_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wen  (reg_wen),
    .addr (reg_addr),
    .strb (strb)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign wbits[i] = reg_wdata[EVT_POS[i]];

    evt_irq_slice u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_evt (evt_vec[i]),
      .strb   (strb),
      .wbit   (wbits[i]),
      .raw_q  (raw_bits[i]),
      .mask_q (mask_bits[i])
    );
  end

  // Scatter the event slices onto their fixed bit positions; other bits stay zero.
  always_comb begin
    raw_vec  = '0;
    mask_vec = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      raw_vec[EVT_POS[i]]  = raw_bits[i];
      mask_vec[EVT_POS[i]] = mask_bits[i];
    end
  end

  assign unused_wdata = ^reg_wdata;

  evt_irq_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .addr     (reg_addr),
    .raw_vec  (raw_vec),
    .mask_vec (mask_vec),
    .rdata    (reg_rdata),
    .irq      (irq)
  );
endmodule

// File: rtl/evt_irq_bank_chk.sv
module evt_irq_bank_chk
  import evt_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wen,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              evt_ch0,
  input logic              evt_ch1,
  input logic              evt_ovf,
  input logic              irq,
  input logic [DATA_W-1:0] raw,
  input logic [DATA_W-1:0] mask
);
  logic [DATA_W-1:0] valid_bits;
  always_comb begin
    valid_bits = '0;
    for (int i = 0; i < NUM_EVT; i++) valid_bits[EVT_POS[i]] = 1'b1;
  end

  logic clr_wr, mkset_wr;
  assign clr_wr   = reg_wen && (reg_addr == ADDR_W'(A_ST_CLR));
  assign mkset_wr = reg_wen && (reg_addr == ADDR_W'(A_MK_SET));

  a_r2_ch0_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ch0 |=> raw[0]);
  a_r2_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |=> raw[6]);
  a_r5_clear_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && reg_wdata[0] && !evt_ch0) |=> !raw[0]);
  a_r9_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && reg_wdata[1] && evt_ch1) |=> raw[1]);
  a_r7_mask_set_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (mkset_wr && reg_wdata[6]) |=> mask[6]);
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw | mask) & ~valid_bits) == '0);
  a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(raw & mask)));
endmodule

bind evt_irq_bank evt_irq_bank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wen   (reg_wen),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .evt_ch0   (evt_ch0),
  .evt_ch1   (evt_ch1),
  .evt_ovf   (evt_ovf),
  .irq       (irq),
  .raw       (raw_vec),
  .mask      (mask_vec)
);

// File: tb/test_evt_irq_bank.sv
`timescale 1ns/1ps
module test_evt_irq_bank;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wen = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              evt_ch0 = 1'b0, evt_ch1 = 1'b0, evt_ovf = 1'b0;
  logic              irq;

  always #4 clk = ~clk;

  evt_irq_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_evt_irq_bank (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_ch0(evt_ch0),
    .evt_ch1(evt_ch1), .evt_ovf(evt_ovf), .irq(irq)
  );

  typedef struct {
    logic [DATA_W-1:0] data;
    logic              irq;
    string             tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  logic done = 1'b0;

  // Reference state, updated from the requirements.
  logic [DATA_W-1:0] m_raw = '0;
  logic [DATA_W-1:0] m_mask = '0;
  localparam logic [DATA_W-1:0] VALID = DATA_W'(32'h43);

  function automatic logic [DATA_W-1:0] evt_bits(logic [2:0] e);
    logic [DATA_W-1:0] v = '0;
    v[0] = e[0]; v[1] = e[1]; v[6] = e[2];
    return v;
  endfunction

  // Drive one cycle of write and/or event pulses, then update the model.
  task automatic cycle_op(input logic wen, input int addr, input logic [DATA_W-1:0] d,
                          input logic [2:0] e);
    logic [DATA_W-1:0] st_set, st_clr;
    @(negedge clk);
    reg_wen = wen; reg_addr = ADDR_W'(addr); reg_wdata = d;
    {evt_ovf, evt_ch1, evt_ch0} = e;
    st_set = (wen && addr == 3) ? (d & VALID) : '0;
    st_clr = (wen && addr == 4) ? (d & VALID) : '0;
    m_raw = (m_raw & ~st_clr) | st_set | evt_bits(e);
    if (wen && addr == 1) m_mask = d & VALID;
    else if (wen && addr == 5) m_mask = m_mask | (d & VALID);
    else if (wen && addr == 6) m_mask = m_mask & ~(d & VALID);
    @(negedge clk);
    reg_wen = 1'b0; {evt_ovf, evt_ch1, evt_ch0} = 3'b000;
  endtask

  // Present a read address and push the expected result for the monitor.
  task automatic expect_rd(input int addr, input string tag);
    exp_t it;
    logic [DATA_W-1:0] v;
    case (addr)
      0: v = m_raw;
      1: v = m_mask;
      2: v = m_raw & m_mask;
      default: v = '0;
    endcase
    @(negedge clk);
    reg_addr = ADDR_W'(addr);
    it.data = v; it.irq = |(m_raw & m_mask); it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Monitor: samples mid-low-phase, after the driver has settled the address.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        n_chk++;
        if (reg_rdata !== it.data || irq !== it.irq) begin
          n_fail++;
          $display("FAIL %s: addr=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
                   it.tag, reg_addr, reg_rdata, irq, it.data, it.irq);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at every address
    for (int a = 0; a < 8; a++) expect_rd(a, "R1 reset");
    // R2: each event pulse lands on its own bit and sticks; R10 stays low while masked
    cycle_op(1'b0, 0, '0, 3'b001); expect_rd(0, "R2 ch0 bit0");
    cycle_op(1'b0, 0, '0, 3'b100); expect_rd(0, "R2 ovf bit6");
    cycle_op(1'b0, 0, '0, 3'b010); expect_rd(0, "R2 ch1 bit1 R10 masked low");
    expect_rd(2, "R3 masked all zero");
    // R5: clear while masked, bits at zero untouched
    cycle_op(1'b1, 4, 32'h0000_0001, 3'b000); expect_rd(0, "R5 clear masked ch0");
    cycle_op(1'b1, 4, 32'h0, 3'b000); expect_rd(0, "R5 zero clear no effect");
    expect_rd(4, "R5 clear port reads zero");
    // R6 / R8: direct mask write of all ones keeps only event bits
    cycle_op(1'b1, 1, '1, 3'b000); expect_rd(1, "R6 R8 mask readback");
    expect_rd(2, "R3 masked view"); // R10 irq high
    cycle_op(1'b1, 4, '1, 3'b000); expect_rd(0, "R5 clear enabled all");
    // R4: software set, zero set, readback
    cycle_op(1'b1, 3, 32'h0000_0002, 3'b000); expect_rd(2, "R4 R10 set ch1 irq");
    cycle_op(1'b1, 3, 32'h0, 3'b000); expect_rd(0, "R4 zero set no effect");
    expect_rd(3, "R4 set port reads zero");
    // R7: mask clear and set ports
    cycle_op(1'b1, 6, 32'h0000_0002, 3'b000); expect_rd(1, "R7 mask clear ch1");
    expect_rd(2, "R7 R10 irq drops");
    cycle_op(1'b1, 6, 32'h0, 3'b000); expect_rd(1, "R7 zero mask clear");
    cycle_op(1'b1, 5, 32'h0000_0002, 3'b000); expect_rd(1, "R7 mask set ch1");
    expect_rd(5, "R7 mask set port reads zero");
    expect_rd(6, "R7 mask clear port reads zero");
    // R8: writes to read-only and unused addresses change nothing
    cycle_op(1'b1, 0, '1, 3'b000); expect_rd(0, "R8 raw ignores write");
    cycle_op(1'b1, 2, '1, 3'b000); expect_rd(0, "R8 masked ignores write");
    cycle_op(1'b1, 7, '1, 3'b000); expect_rd(1, "R8 spare write mask intact");
    expect_rd(7, "R8 spare reads zero");
    cycle_op(1'b1, 3, '1, 3'b000); expect_rd(0, "R8 set all ones only event bits");
    // R9: event pulse and clear on the same edge
    cycle_op(1'b1, 4, 32'h0000_0001, 3'b001); expect_rd(0, "R9 ch0 event beats clear");
    cycle_op(1'b1, 4, 32'h0000_0040, 3'b100); expect_rd(2, "R9 ovf event beats clear");
    cycle_op(1'b1, 4, '1, 3'b000); expect_rd(2, "R10 all cleared irq low");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule